// File: doc/BRIEF.md
# Overhead Data Channel Extractor

This block sits behind a frame aligner. It receives one overhead or payload byte per valid cycle, along with the byte's row (1 to 9) and column (1 to 90) inside the frame. From that stream it takes two management data channels.

- The **narrow channel** is the three bytes at the start of row 3.
- The **wide channel** is the three leading bytes of each of rows 6, 7 and 8, which gives nine bytes per frame.

Each channel drops its bytes into a private buffer deep enough for two frames. From there a serializer sends the bytes at a constant rate on a three-wire link made of a data bit, a link clock derived from the system clock, and a start-of-frame marker. The wide link runs three times faster than the narrow one, so both links need the same time per frame.

Downstream receivers sample each link on the rising edge of its clock. The start-of-frame marker tells them which byte opens a frame's group. Each link also has a sticky underrun flag. It shows that a link ran dry between two bytes of the same frame.

Top module: `dcc_extract`

## Requirements
- R1: A valid byte at row 3, columns 1 to 3, is sent on the narrow link. Bytes go out in the order they arrived.
- R2: A valid byte at rows 6 to 8, columns 1 to 3, is sent on the wide link. Bytes go out in arrival order, which is row by row and column by column.
- R3: The following bytes never appear on either link:
  - bytes at any other row or column;
  - bytes presented while the valid input is low.
- R4: Each byte is sent most significant bit first. Each bit is held for one full link clock period. Data and start-of-frame change only in the system cycle in which the link clock falls.
- R5: The wide link clock has a period of 2·HI_HALF system cycles, which is 8 by default. The narrow link clock has a period LO_RATIO times longer, which is 24 by default.
- R6: The start-of-frame output is high for exactly the eight bit periods of a group's first byte. The first byte is row 3 column 1 for the narrow link and row 6 column 1 for the wide link. The output is low during every other byte.
- R7: While a link has nothing buffered, its data and start-of-frame outputs stay at 0.
- R8: The underrun flag rises if a link's buffer is empty at the moment the next byte of a partly sent group is due. The flag stays high until reset. Running empty after a group's last byte does not raise it.
- R9: A synchronous active-high reset sets all link outputs and flags to 0. Each buffer holds at least two frames' worth of bytes, so two back-to-back frames pass without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| oct_vld | input | 1 | Byte on oct_data is valid |
| oct_data | input | 8 | Frame byte |
| oct_row | input | 4 | Row of the byte, 1 to 9 |
| oct_col | input | 7 | Column of the byte, 1 to 90 |
| lo_sdata | output | 1 | Narrow link serial data |
| lo_sclk | output | 1 | Narrow link clock |
| lo_sof | output | 1 | Narrow link start-of-frame marker |
| lo_underrun | output | 1 | Narrow link sticky underrun flag |
| hi_sdata | output | 1 | Wide link serial data |
| hi_sclk | output | 1 | Wide link clock |
| hi_sof | output | 1 | Wide link start-of-frame marker |
| hi_underrun | output | 1 | Wide link sticky underrun flag |

## Verification
A table of bytes is applied first. It spans all nine rows and touches the columns just past the channel window. This separates correct position decoding from off-by-one row and column mistakes. Its data values (all zeros, all ones, alternating bits, single set bits at either end) would expose a bit-order or shift error.

Two generated frames then follow back to back with no gap. They check that the buffers absorb a second frame and that the start-of-frame marker realigns on the next group. A byte presented with valid low checks that it is dropped. A frame whose wide group stalls after its first row separates a mid-group underrun from the harmless idle time between frames.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    localparam int BYTE_W       = 8;
    localparam int ROW_W        = 4;
    localparam int COL_W        = 7;
    localparam int LO_ROW       = 3;
    localparam int HI_ROW_FIRST = 6;
    localparam int HI_ROW_LAST  = 8;
    localparam int DCC_COLS     = 3;

    typedef enum logic {
        CH_LO = 1'b0,
        CH_HI = 1'b1
    } dcc_ch_e;

    typedef struct packed {
        logic              first;
        logic              last;
        logic [BYTE_W-1:0] data;
    } dcc_ent_t;

    typedef struct packed {
        logic hit;
        logic first;
        logic last;
    } dcc_pos_t;

    // Classify a row/column position for one channel.
    function automatic dcc_pos_t pos_decode(dcc_ch_e ch,
                                            logic [ROW_W-1:0] row,
                                            logic [COL_W-1:0] col);
        dcc_pos_t p;
        logic     col_ok;
        col_ok = (col >= COL_W'(1)) && (col <= COL_W'(DCC_COLS));
        p      = '0;
        if (ch == CH_LO) begin
            p.hit   = col_ok && (row == ROW_W'(LO_ROW));
            p.first = p.hit && (col == COL_W'(1));
            p.last  = p.hit && (col == COL_W'(DCC_COLS));
        end else begin
            p.hit   = col_ok && (row >= ROW_W'(HI_ROW_FIRST)) && (row <= ROW_W'(HI_ROW_LAST));
            p.first = p.hit && (row == ROW_W'(HI_ROW_FIRST)) && (col == COL_W'(1));
            p.last  = p.hit && (row == ROW_W'(HI_ROW_LAST)) && (col == COL_W'(DCC_COLS));
        end
        return p;
    endfunction

endpackage

// File: rtl/dcc_tap.sv
module dcc_tap
    import dcc_pkg::*;
#(
    parameter dcc_ch_e CH = CH_LO
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vld,
    input  logic [BYTE_W-1:0] data,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    output logic              push,
    output dcc_ent_t          ent
);

    dcc_pos_t pos;

    always_comb pos = pos_decode(CH, row, col);

    always_ff @(posedge clk) begin
        if (rst) begin
            push <= 1'b0;
            ent  <= '0;
        end else begin
            push      <= vld && pos.hit;
            ent.first <= pos.first;
            ent.last  <= pos.last;
            ent.data  <= data;
        end
    end

endmodule

// File: rtl/dcc_fifo.sv
module dcc_fifo
    import dcc_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  dcc_ent_t din,
    input  logic     pop,
    output dcc_ent_t dout,
    output logic     empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    dcc_ent_t      mem [DEPTH];
    logic [AW:0]   wp, rp;
    logic          full;

    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign dout  = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (push && !full) mem[wp[AW-1:0]] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full) wp <= wp + (AW+1)'(1);
            if (pop && !empty) rp <= rp + (AW+1)'(1);
        end
    end

endmodule

// File: rtl/dcc_serializer.sv
module dcc_serializer
    import dcc_pkg::*;
#(
    parameter int HALF = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     empty,
    input  dcc_ent_t ent,
    output logic     pop,
    output logic     sdata,
    output logic     sclk,
    output logic     sof,
    output logic     underrun
);

    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0]     div_cnt;
    logic              sclk_q;
    logic [BYTE_W-1:0] shreg;
    logic [2:0]        bit_idx;
    logic              busy;
    logic              cur_last;
    logic              sof_q;
    logic              urun_q;
    logic              tick;
    logic              fall;
    logic              last_bit;

    assign tick     = (div_cnt == CW'(HALF - 1));
    assign fall     = tick && sclk_q;
    assign last_bit = (bit_idx == 3'd7);
    assign pop      = fall && (!busy || last_bit) && !empty;

    assign sdata    = shreg[BYTE_W-1];
    assign sclk     = sclk_q;
    assign sof      = sof_q;
    assign underrun = urun_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt  <= '0;
            sclk_q   <= 1'b0;
            shreg    <= '0;
            bit_idx  <= '0;
            busy     <= 1'b0;
            cur_last <= 1'b0;
            sof_q    <= 1'b0;
            urun_q   <= 1'b0;
        end else begin
            div_cnt <= tick ? '0 : div_cnt + CW'(1);
            if (tick) sclk_q <= ~sclk_q;
            if (fall) begin
                if (busy && !last_bit) begin
                    shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                    bit_idx <= bit_idx + 3'd1;
                end else if (!empty) begin
                    shreg    <= ent.data;
                    bit_idx  <= '0;
                    busy     <= 1'b1;
                    cur_last <= ent.last;
                    sof_q    <= ent.first;
                end else begin
                    shreg   <= '0;
                    bit_idx <= '0;
                    busy    <= 1'b0;
                    sof_q   <= 1'b0;
                    if (busy && !cur_last) urun_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dcc_extract.sv
module dcc_extract
    import dcc_pkg::*;
#(
    parameter int HI_HALF  = 4,
    parameter int LO_RATIO = 3,
    parameter int LO_DEPTH = 8,
    parameter int HI_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              oct_vld,
    input  logic [BYTE_W-1:0] oct_data,
    input  logic [ROW_W-1:0]  oct_row,
    input  logic [COL_W-1:0]  oct_col,
    output logic              lo_sdata,
    output logic              lo_sclk,
    output logic              lo_sof,
    output logic              lo_underrun,
    output logic              hi_sdata,
    output logic              hi_sclk,
    output logic              hi_sof,
    output logic              hi_underrun
);

    localparam int NCH = 2;

    logic [NCH-1:0] sd, sc, sf, ur;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int      HALF_C  = (c == 0) ? HI_HALF * LO_RATIO : HI_HALF;
        localparam int      DEPTH_C = (c == 0) ? LO_DEPTH : HI_DEPTH;
        localparam dcc_ch_e CH_C    = (c == 0) ? CH_LO : CH_HI;

        dcc_ent_t t_ent, h_ent;
        logic     t_push, f_pop, f_empty;

        dcc_tap #(.CH(CH_C)) u_tap (
            .clk  (clk),
            .rst  (rst),
            .vld  (oct_vld),
            .data (oct_data),
            .row  (oct_row),
            .col  (oct_col),
            .push (t_push),
            .ent  (t_ent)
        );

        dcc_fifo #(.DEPTH(DEPTH_C)) u_buf (
            .clk   (clk),
            .rst   (rst),
            .push  (t_push),
            .din   (t_ent),
            .pop   (f_pop),
            .dout  (h_ent),
            .empty (f_empty)
        );

        dcc_serializer #(.HALF(HALF_C)) u_ser (
            .clk      (clk),
            .rst      (rst),
            .empty    (f_empty),
            .ent      (h_ent),
            .pop      (f_pop),
            .sdata    (sd[c]),
            .sclk     (sc[c]),
            .sof      (sf[c]),
            .underrun (ur[c])
        );
    end

    assign lo_sdata    = sd[0];
    assign lo_sclk     = sc[0];
    assign lo_sof      = sf[0];
    assign lo_underrun = ur[0];
    assign hi_sdata    = sd[1];
    assign hi_sclk     = sc[1];
    assign hi_sof      = sf[1];
    assign hi_underrun = ur[1];

endmodule

// File: rtl/dcc_extract_chk.sv
module dcc_extract_chk #(
    parameter int HI_HALF  = 4,
    parameter int LO_RATIO = 3
) (
    input logic clk,
    input logic rst,
    input logic lo_sdata,
    input logic lo_sclk,
    input logic lo_sof,
    input logic lo_underrun,
    input logic hi_sdata,
    input logic hi_sclk,
    input logic hi_sof,
    input logic hi_underrun
);

    int   lo_gap, hi_gap;
    logic lo_sclk_d, hi_sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_gap    <= 0;
            hi_gap    <= 0;
            lo_sclk_d <= 1'b0;
            hi_sclk_d <= 1'b0;
        end else begin
            lo_sclk_d <= lo_sclk;
            hi_sclk_d <= hi_sclk;
            lo_gap    <= (lo_sclk != lo_sclk_d) ? 0 : lo_gap + 1;
            hi_gap    <= (hi_sclk != hi_sclk_d) ? 0 : hi_gap + 1;
        end
    end

    p_lo_data_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        (lo_sdata != $past(lo_sdata)) |-> ($past(lo_sclk) && !lo_sclk));

    p_hi_data_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        (hi_sdata != $past(hi_sdata)) |-> ($past(hi_sclk) && !hi_sclk));

    p_lo_sof_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
        (lo_sof != $past(lo_sof)) |-> ($past(lo_sclk) && !lo_sclk));

    p_hi_sof_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
        (hi_sof != $past(hi_sof)) |-> ($past(hi_sclk) && !hi_sclk));

    p_lo_urun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        $past(lo_underrun) |-> lo_underrun);

    p_hi_urun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        $past(hi_underrun) |-> hi_underrun);

    p_hi_clk_gap_r5: assert property (@(posedge clk) disable iff (rst)
        hi_gap <= HI_HALF);

    p_lo_clk_gap_r5: assert property (@(posedge clk) disable iff (rst)
        lo_gap <= HI_HALF * LO_RATIO);

endmodule

bind dcc_extract dcc_extract_chk #(
    .HI_HALF  (HI_HALF),
    .LO_RATIO (LO_RATIO)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .lo_sdata    (lo_sdata),
    .lo_sclk     (lo_sclk),
    .lo_sof      (lo_sof),
    .lo_underrun (lo_underrun),
    .hi_sdata    (hi_sdata),
    .hi_sclk     (hi_sclk),
    .hi_sof      (hi_sof),
    .hi_underrun (hi_underrun)
);

// File: tb/dcc_extract_test.sv
module dcc_extract_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       oct_vld = 1'b0;
    logic [7:0] oct_data = '0;
    logic [3:0] oct_row = '0;
    logic [6:0] oct_col = '0;
    logic lo_sdata, lo_sclk, lo_sof, lo_underrun;
    logic hi_sdata, hi_sclk, hi_sof, hi_underrun;

    always #2 clk = ~clk;

    dcc_extract uut (
        .clk(clk), .rst(rst), .oct_vld(oct_vld), .oct_data(oct_data),
        .oct_row(oct_row), .oct_col(oct_col),
        .lo_sdata(lo_sdata), .lo_sclk(lo_sclk), .lo_sof(lo_sof), .lo_underrun(lo_underrun),
        .hi_sdata(hi_sdata), .hi_sclk(hi_sclk), .hi_sof(hi_sof), .hi_underrun(hi_underrun)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    // row[20:17] col[16:10] data[9:2] tag[1:0]: 0 none, 1 narrow, 2 wide
    localparam int NV = 19;
    localparam logic [20:0] VEC [NV] = '{
        {4'd1, 7'd1,  8'hF6, 2'd0}, {4'd2, 7'd1,  8'h11, 2'd0},
        {4'd3, 7'd1,  8'hC3, 2'd1}, {4'd3, 7'd2,  8'h3C, 2'd1},
        {4'd3, 7'd3,  8'h81, 2'd1}, {4'd3, 7'd4,  8'h7E, 2'd0},
        {4'd4, 7'd2,  8'h55, 2'd0}, {4'd5, 7'd3,  8'hAA, 2'd0},
        {4'd6, 7'd1,  8'hA5, 2'd2}, {4'd6, 7'd2,  8'h5A, 2'd2},
        {4'd6, 7'd3,  8'hFF, 2'd2}, {4'd6, 7'd90, 8'h12, 2'd0},
        {4'd7, 7'd1,  8'h00, 2'd2}, {4'd7, 7'd2,  8'h01, 2'd2},
        {4'd7, 7'd3,  8'h80, 2'd2}, {4'd8, 7'd1,  8'h69, 2'd2},
        {4'd8, 7'd2,  8'h96, 2'd2}, {4'd8, 7'd3,  8'hE7, 2'd2},
        {4'd9, 7'd1,  8'h99, 2'd0}
    };

    logic [7:0] exp_lo [$];
    logic [7:0] exp_hi [$];

    // link monitor
    logic       mon_en = 1'b1;
    logic       prev_c [2];
    int         bytes_left [2];
    int         bit_n [2];
    logic       in_first [2];
    logic [7:0] acc [2];

    function automatic logic [2:0] link(int ch);
        return (ch == 0) ? {lo_sdata, lo_sclk, lo_sof} : {hi_sdata, hi_sclk, hi_sof};
    endfunction

    always @(negedge clk) begin
        for (int ch = 0; ch < 2; ch++) begin
            logic [2:0] l;
            logic [7:0] e;
            l = link(ch);
            if (rst || !mon_en) begin
                bytes_left[ch] = 0; bit_n[ch] = 0; in_first[ch] = 1'b0;
                prev_c[ch] = l[1];
            end else begin
                if (l[1] && !prev_c[ch]) begin
                    if (bytes_left[ch] == 0 && bit_n[ch] == 0 && l[0]) begin
                        bytes_left[ch] = (ch == 0) ? 3 : 9;
                        in_first[ch]   = 1'b1;
                    end
                    if (bytes_left[ch] != 0) begin
                        if (l[0] != in_first[ch]) begin
                            n_chk++; n_bad++;
                            $display("FAIL R6 ch%0d sof actual=%b expected=%b", ch, l[0], in_first[ch]);
                        end
                        acc[ch] = {acc[ch][6:0], l[2]};
                        bit_n[ch]++;
                        if (bit_n[ch] == 8) begin
                            bit_n[ch] = 0;
                            bytes_left[ch]--;
                            in_first[ch] = 1'b0;
                            n_chk++;
                            if (ch == 0) e = (exp_lo.size() != 0) ? exp_lo.pop_front() : 8'hxx;
                            else         e = (exp_hi.size() != 0) ? exp_hi.pop_front() : 8'hxx;
                            if (acc[ch] !== e) begin
                                n_bad++;
                                $display("FAIL %s/R4 ch%0d byte actual=%h expected=%h",
                                         (ch == 0) ? "R1" : "R2", ch, acc[ch], e);
                            end
                        end
                    end
                end
                prev_c[ch] = l[1];
            end
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(logic [3:0] r, logic [6:0] c, logic [7:0] d, logic v);
        @(negedge clk);
        oct_row = r; oct_col = c; oct_data = d; oct_vld = v;
    endtask

    task automatic idle(int n);
        @(negedge clk);
        oct_vld = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic measure(int ch, int exp_per);
        int cnt;
        logic p;
        p = link(ch)[1];
        forever begin @(negedge clk); if (link(ch)[1] && !p) break; p = link(ch)[1]; end
        cnt = 0; p = 1'b1;
        forever begin @(negedge clk); cnt++; if (link(ch)[1] && !p) break; p = link(ch)[1]; end
        check("R5 clock period", 8'(cnt), 8'(exp_per));
    endtask

    initial begin
        do_reset();
        // R9: reset state
        @(negedge clk);
        check("R9 reset outputs", {lo_sdata, lo_sclk, lo_sof, lo_underrun,
                                   hi_sdata, hi_sclk, hi_sof, hi_underrun}, 8'h00);

        // table walk (R1, R2, R3)
        for (int i = 0; i < NV; i++) begin
            put(VEC[i][20:17], VEC[i][16:10], VEC[i][9:2], 1'b1);
            if (VEC[i][1:0] == 2'd1) exp_lo.push_back(VEC[i][9:2]);
            if (VEC[i][1:0] == 2'd2) exp_hi.push_back(VEC[i][9:2]);
        end
        idle(1500);
        check("R1 narrow bytes all sent", 8'(exp_lo.size()), 8'd0);
        check("R2 wide bytes all sent", 8'(exp_hi.size()), 8'd0);
        // R8: running empty between groups is not an underrun
        check("R8 no underrun between frames", {6'd0, lo_underrun, hi_underrun}, 8'd0);
        // R7: idle links hold zero
        check("R7 idle data/sof", {4'd0, lo_sdata, lo_sof, hi_sdata, hi_sof}, 8'd0);

        // R5: link clock periods
        measure(1, 8);
        measure(0, 24);

        // R3: a channel byte with valid low is dropped; then two back-to-back frames (R9)
        put(4'd3, 7'd1, 8'hEE, 1'b0);
        put(4'd6, 7'd1, 8'hDD, 1'b0);
        for (int f = 2; f <= 3; f++) begin
            for (int r = 1; r <= 9; r++) begin
                for (int c = 1; c <= 4; c++) begin
                    logic [7:0] d;
                    d = 8'((f * 37 + r * 11 + c * 5)) ^ 8'h5C;
                    put(4'(r), 7'(c), d, 1'b1);
                    if (c <= 3 && r == 3) exp_lo.push_back(d);
                    if (c <= 3 && r >= 6 && r <= 8) exp_hi.push_back(d);
                end
            end
        end
        idle(2000);
        check("R9 narrow two frames drained", 8'(exp_lo.size()), 8'd0);
        check("R9 wide two frames drained", 8'(exp_hi.size()), 8'd0);
        check("R3 dropped bytes absent (R7 idle)", {6'd0, lo_sdata, hi_sdata}, 8'd0);

        // R8: wide group stalls after its first row
        mon_en = 1'b0;
        do_reset();
        put(4'd6, 7'd1, 8'h01, 1'b1);
        put(4'd6, 7'd2, 8'h02, 1'b1);
        put(4'd6, 7'd3, 8'h03, 1'b1);
        idle(800);
        check("R8 wide underrun raised", {7'd0, hi_underrun}, 8'd1);
        check("R8 narrow no underrun", {7'd0, lo_underrun}, 8'd0);
        put(4'd7, 7'd1, 8'h04, 1'b1);
        idle(400);
        check("R8 underrun sticky", {7'd0, hi_underrun}, 8'd1);
        do_reset();
        @(negedge clk);
        check("R9 reset clears underrun", {6'd0, lo_underrun, hi_underrun}, 8'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(negedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule